// File: doc/BRIEF.md
# Four-Slot Instruction Decode Steering with Pair and Load-Op Fusion

This block sits after instruction pre-decode. Each cycle it looks at a window of up to six instruction descriptors held in program order. Each descriptor carries a valid bit, a byte length from 1 to 15, a raw micro-op count, and three flags. The flags mark a compare that can head a fused pair, a conditional branch that can close one, and a load-plus-ALU read-modify-write whose load and operation merge into one micro-op. The block steers the leading instructions into four decoders. Decoder 0 can expand one instruction into as many as four micro-ops. Decoders 1 to 3 accept only instructions that produce exactly one micro-op.

The block writes a four-entry micro-op bundle into a register. Every entry carries a valid bit, a fused flag, the number of instructions it stands for, and the window index of its source instruction. In the same cycle the block tells the upstream window how many instructions it took and how many bytes they span, so the window can shift before the next edge. An instruction that would still need more than four micro-ops after load fusion is sent to the microcode sequencer, but only when it leads the window. A busy sequencer blocks all intake.

Top module: `decode_steer`

## Requirements
- R1: While reset is asserted, and after it is released until the first decode, all four `uop_valid` bits, `ucode_start` and `ucode_uops` are 0.
- R2: Single-micro-op instructions are taken in program order, one per decoder, at most four per cycle. Each gives one valid micro-op with `uop_icnt`=1, `uop_fused`=0 and its window index in `uop_src`. Bundle entry k, for k from 0 to 3, sits at bit k of `uop_valid`/`uop_fused`, bits [2k+1:2k] of `uop_icnt` and bits [3k+2:3k] of `uop_src`. `take_cnt` is valid in the same cycle. The bundle appears after the next rising edge.
- R3: An instruction with an effective count of 2 to 4 is decoded only as the first instruction of the cycle. Its micro-ops fill consecutive entries starting at 0, all with the same `uop_src`. If such an instruction comes later in the window, decoding stops just before it.
- R4: The bundle never holds more than four micro-ops, and its valid entries are always packed from entry 0 upward. Decoding stops at the first instruction whose micro-ops no longer fit.
- R5: A compare flagged in `win_cmp` at index i, followed by a valid conditional branch flagged in `win_jcc` at i+1, forms one micro-op when both have an effective count of 1. That micro-op has `uop_fused`=1 and `uop_icnt`=2, uses one decoder, and takes `uop_src`=i. Only the first such pair in a cycle is fused, so up to five instructions are taken per cycle.
- R6: When `win_ld` is set and the raw count is at least 2, the effective count is the raw count minus one. Only the first micro-op of that instruction has `uop_fused`=1, and its `uop_icnt` is 1.
- R7: If the first window entry has an effective count above 4, `take_cnt`=1 and no micro-ops are produced. After the next edge, `ucode_start` pulses for one cycle with `ucode_uops` equal to the effective count, and the bundle is empty. If such an entry is not first, decoding stops just before it.
- R8: While `ucode_busy` is 1, `in_ready`=0, `take_cnt`=0, `take_bytes`=0, and the next bundle is empty with no `ucode_start`.
- R9: `take_bytes` equals the sum of the lengths of the entries taken in that cycle.
- R10: An invalid window entry ends the window. Nothing at or after it is taken, and a compare just before it is not fused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | WIN | Entry valid, bit i = entry i |
| win_len | input | 4*WIN | Byte length per entry, entry i at [4i+3:4i] |
| win_uops | input | 3*WIN | Raw micro-op count per entry, entry i at [3i+2:3i] |
| win_cmp | input | WIN | Entry may head a fused pair |
| win_jcc | input | WIN | Entry is a conditional branch that may close a pair |
| win_ld | input | WIN | Entry is a load-op whose load merges with the ALU step |
| ucode_busy | input | 1 | Microcode sequencer is busy |
| in_ready | output | 1 | Window is accepted this cycle |
| take_cnt | output | $clog2(WIN+1) | Instructions consumed this cycle |
| take_bytes | output | $clog2(15*WIN+1) | Bytes consumed this cycle |
| uop_valid | output | NUOP | Bundle entry valid |
| uop_fused | output | NUOP | Bundle entry is fused |
| uop_icnt | output | 2*NUOP | Instructions represented per entry (1 or 2) |
| uop_src | output | $clog2(WIN)*NUOP | Window index of the source instruction per entry |
| ucode_start | output | 1 | One-cycle hand-off pulse to the microcode sequencer |
| ucode_uops | output | 3 | Effective micro-op count handed off |

## Verification
`in_ready`, `take_cnt` and `take_bytes` are combinational, so they are due in the same cycle as the window they describe. The bench checks them 1 ns after driving inputs on the falling edge. The bundle, `ucode_start` and `ucode_uops` are registered once, so they are due one rising edge later. The bench reads them on the following falling edge, before it drives the next window. Placing the busy vector right after the microcode vector tests that the hand-off pulse lasts one cycle. The reset cases are checked while reset is held and on the first edge after it is released.

// File: rtl/decode_steer_pkg.sv
package decode_steer_pkg;
  localparam int LENW = 4;
  localparam int UOPW = 3;

  // micro-ops left after a load-op merge
  function automatic logic [UOPW-1:0] eff_uops(input logic [UOPW-1:0] raw, input logic ld);
    if (ld && raw >= UOPW'(2)) return raw - UOPW'(1);
    return raw;
  endfunction
endpackage

// File: rtl/dsf_assign.sv
module dsf_assign
  import decode_steer_pkg::*;
#(
  parameter int WIN   = 6,
  parameter int NDEC  = 4,
  parameter int NUOP  = 4,
  parameter int CXMAX = 4,
  parameter int IDXW  = 3,
  parameter int CNTW  = 3
) (
  input  logic                 enable,
  input  logic [WIN-1:0]       win_valid,
  input  logic [UOPW*WIN-1:0]  win_uops,
  input  logic [WIN-1:0]       win_cmp,
  input  logic [WIN-1:0]       win_jcc,
  input  logic [WIN-1:0]       win_ld,
  output logic [NUOP-1:0]      nx_valid,
  output logic [NUOP-1:0]      nx_fused,
  output logic [2*NUOP-1:0]    nx_icnt,
  output logic [IDXW*NUOP-1:0] nx_src,
  output logic [CNTW-1:0]      take_cnt,
  output logic                 ucode_fire,
  output logic [UOPW-1:0]      ucode_cnt,
  output logic                 pair_fire
);
  always_comb begin
    int p;
    int pos;
    logic stop;
    logic two;
    logic mfu;
    logic [UOPW-1:0] e;
    nx_valid   = '0;
    nx_fused   = '0;
    nx_icnt    = '0;
    nx_src     = '0;
    ucode_fire = 1'b0;
    ucode_cnt  = '0;
    pair_fire  = 1'b0;
    p    = 0;
    pos  = 0;
    stop = 1'b0;
    two  = 1'b0;
    mfu  = 1'b0;
    e    = eff_uops(win_uops[0 +: UOPW], win_ld[0]);
    if (!enable || !win_valid[0]) begin
      stop = 1'b1;
    end else if (int'(e) > CXMAX) begin
      ucode_fire = 1'b1;
      ucode_cnt  = e;
      p          = 1;
      stop       = 1'b1;
    end
    for (int d = 0; d < NDEC; d++) begin
      if (!stop) begin
        if (p >= WIN) begin
          stop = 1'b1;
        end else if (!win_valid[p]) begin
          stop = 1'b1;
        end else begin
          e   = eff_uops(win_uops[p*UOPW +: UOPW], win_ld[p]);
          mfu = (e != win_uops[p*UOPW +: UOPW]);
          if (int'(e) > CXMAX) stop = 1'b1;
          else if (int'(e) > 1 && d != 0) stop = 1'b1;
          else if (pos + int'(e) > NUOP) stop = 1'b1;
          else begin
            two = 1'b0;
            if (int'(e) == 1 && !pair_fire && win_cmp[p] && (p + 1 < WIN)) begin
              if (win_valid[p+1] && win_jcc[p+1] &&
                  eff_uops(win_uops[(p+1)*UOPW +: UOPW], win_ld[p+1]) == UOPW'(1))
                two = 1'b1;
            end
            for (int k = 0; k < NUOP; k++) begin
              if (k >= pos && k < pos + int'(e)) begin
                nx_valid[k]               = 1'b1;
                nx_src[k*IDXW +: IDXW]    = IDXW'(p);
                nx_icnt[2*k +: 2]         = two ? 2'd2 : 2'd1;
                nx_fused[k]               = two || (mfu && k == pos);
              end
            end
            pair_fire = pair_fire | two;
            pos       = pos + int'(e);
            p         = p + (two ? 2 : 1);
          end
        end
      end
    end
    take_cnt = CNTW'(p);
  end
endmodule

// File: rtl/dsf_bytes.sv
module dsf_bytes
  import decode_steer_pkg::*;
#(
  parameter int WIN  = 6,
  parameter int CNTW = 3,
  parameter int BYTW = 7
) (
  input  logic [LENW*WIN-1:0] win_len,
  input  logic [CNTW-1:0]     take_cnt,
  output logic [BYTW-1:0]     take_bytes
);
  always_comb begin
    take_bytes = '0;
    for (int i = 0; i < WIN; i++)
      if (i < int'(take_cnt)) take_bytes = take_bytes + BYTW'(win_len[i*LENW +: LENW]);
  end
endmodule

// File: rtl/dsf_bundle_reg.sv
module dsf_bundle_reg
  import decode_steer_pkg::*;
#(
  parameter int NUOP = 4,
  parameter int IDXW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUOP-1:0]      nx_valid,
  input  logic [NUOP-1:0]      nx_fused,
  input  logic [2*NUOP-1:0]    nx_icnt,
  input  logic [IDXW*NUOP-1:0] nx_src,
  input  logic                 ucode_fire,
  input  logic [UOPW-1:0]      ucode_cnt,
  output logic [NUOP-1:0]      uop_valid,
  output logic [NUOP-1:0]      uop_fused,
  output logic [2*NUOP-1:0]    uop_icnt,
  output logic [IDXW*NUOP-1:0] uop_src,
  output logic                 ucode_start,
  output logic [UOPW-1:0]      ucode_uops
);
  for (genvar k = 0; k < NUOP; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        uop_valid[k]             <= 1'b0;
        uop_fused[k]             <= 1'b0;
        uop_icnt[2*k +: 2]       <= '0;
        uop_src[k*IDXW +: IDXW]  <= '0;
      end else begin
        uop_valid[k]             <= nx_valid[k];
        uop_fused[k]             <= nx_fused[k];
        uop_icnt[2*k +: 2]       <= nx_icnt[2*k +: 2];
        uop_src[k*IDXW +: IDXW]  <= nx_src[k*IDXW +: IDXW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucode_start <= 1'b0;
      ucode_uops  <= '0;
    end else begin
      ucode_start <= ucode_fire;
      ucode_uops  <= ucode_fire ? ucode_cnt : '0;
    end
  end
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import decode_steer_pkg::*;
#(
  parameter int WIN   = 6,
  parameter int NDEC  = 4,
  parameter int NUOP  = 4,
  parameter int CXMAX = 4,
  localparam int IDXW = $clog2(WIN),
  localparam int CNTW = $clog2(WIN + 1),
  localparam int BYTW = $clog2(15 * WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIN-1:0]       win_valid,
  input  logic [LENW*WIN-1:0]  win_len,
  input  logic [UOPW*WIN-1:0]  win_uops,
  input  logic [WIN-1:0]       win_cmp,
  input  logic [WIN-1:0]       win_jcc,
  input  logic [WIN-1:0]       win_ld,
  input  logic                 ucode_busy,
  output logic                 in_ready,
  output logic [CNTW-1:0]      take_cnt,
  output logic [BYTW-1:0]      take_bytes,
  output logic [NUOP-1:0]      uop_valid,
  output logic [NUOP-1:0]      uop_fused,
  output logic [2*NUOP-1:0]    uop_icnt,
  output logic [IDXW*NUOP-1:0] uop_src,
  output logic                 ucode_start,
  output logic [UOPW-1:0]      ucode_uops
);
  logic [NUOP-1:0]      nx_valid;
  logic [NUOP-1:0]      nx_fused;
  logic [2*NUOP-1:0]    nx_icnt;
  logic [IDXW*NUOP-1:0] nx_src;
  logic                 ucode_fire;
  logic [UOPW-1:0]      ucode_cnt;
  logic                 pair_fire;

  assign in_ready = !ucode_busy;

  dsf_assign #(.WIN(WIN), .NDEC(NDEC), .NUOP(NUOP), .CXMAX(CXMAX), .IDXW(IDXW), .CNTW(CNTW)) u_assign (
    .enable(in_ready), .win_valid(win_valid), .win_uops(win_uops), .win_cmp(win_cmp),
    .win_jcc(win_jcc), .win_ld(win_ld), .nx_valid(nx_valid), .nx_fused(nx_fused),
    .nx_icnt(nx_icnt), .nx_src(nx_src), .take_cnt(take_cnt), .ucode_fire(ucode_fire),
    .ucode_cnt(ucode_cnt), .pair_fire(pair_fire)
  );

  dsf_bytes #(.WIN(WIN), .CNTW(CNTW), .BYTW(BYTW)) u_bytes (
    .win_len(win_len), .take_cnt(take_cnt), .take_bytes(take_bytes)
  );

  dsf_bundle_reg #(.NUOP(NUOP), .IDXW(IDXW)) u_breg (
    .clk(clk), .rst_n(rst_n), .nx_valid(nx_valid), .nx_fused(nx_fused), .nx_icnt(nx_icnt),
    .nx_src(nx_src), .ucode_fire(ucode_fire), .ucode_cnt(ucode_cnt), .uop_valid(uop_valid),
    .uop_fused(uop_fused), .uop_icnt(uop_icnt), .uop_src(uop_src), .ucode_start(ucode_start),
    .ucode_uops(ucode_uops)
  );
endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
  parameter int NUOP = 4,
  parameter int NDEC = 4,
  parameter int CNTW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ucode_busy,
  input logic              in_ready,
  input logic              win_valid0,
  input logic [CNTW-1:0]   take_cnt,
  input logic [NUOP-1:0]   uop_valid,
  input logic [NUOP-1:0]   uop_fused,
  input logic [2*NUOP-1:0] uop_icnt,
  input logic              ucode_start,
  input logic              ucode_fire,
  input logic              pair_fire
);
  logic [NUOP-1:0] pair_slot;
  always_comb
    for (int k = 0; k < NUOP; k++)
      pair_slot[k] = uop_valid[k] && (uop_icnt[2*k +: 2] == 2'd2);

  AST_FIRST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && win_valid0) |-> (take_cnt != '0)); // R2
  AST_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((uop_valid & (uop_valid + NUOP'(1))) == '0)); // R4
  AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(take_cnt) <= NDEC + 1)); // R5
  AST_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pair_slot) <= 1); // R5
  AST_PAIR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((pair_slot & ~uop_fused) == '0)); // R5
  AST_PAIR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> (pair_slot != '0)); // R5
  AST_UC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_fire |=> (ucode_start && uop_valid == '0)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_busy |-> (!in_ready && take_cnt == '0)); // R8
  AST_BUSY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_busy |=> (uop_valid == '0 && !ucode_start)); // R8
endmodule

bind decode_steer decode_steer_chk #(.NUOP(NUOP), .NDEC(NDEC), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ucode_busy(ucode_busy), .in_ready(in_ready),
  .win_valid0(win_valid[0]), .take_cnt(take_cnt), .uop_valid(uop_valid),
  .uop_fused(uop_fused), .uop_icnt(uop_icnt), .ucode_start(ucode_start),
  .ucode_fire(ucode_fire), .pair_fire(pair_fire)
);

// File: tb/decode_steer_tb.sv
`timescale 1ns/1ps
module decode_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  win_valid = '0;
  logic [23:0] win_len = '0;
  logic [17:0] win_uops = '0;
  logic [5:0]  win_cmp = '0, win_jcc = '0, win_ld = '0;
  logic        ucode_busy = 1'b0;
  logic        in_ready;
  logic [2:0]  take_cnt;
  logic [6:0]  take_bytes;
  logic [3:0]  uop_valid, uop_fused;
  logic [7:0]  uop_icnt;
  logic [11:0] uop_src;
  logic        ucode_start;
  logic [2:0]  ucode_uops;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  decode_steer u_dut (.*);

  typedef struct packed {
    logic [5:0]  v, cmp, jcc, ld;
    logic [17:0] uops;
    logic [23:0] len;
    logic        busy;
    logic [2:0]  e_take;
    logic [6:0]  e_bytes;
    logic [3:0]  e_val, e_fus;
    logic [7:0]  e_icnt;
    logic [11:0] e_src;
    logic        e_uc;
    logic [2:0]  e_ucn;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R2: six simple, four taken
    '{v:6'h3F, cmp:0, jcc:0, ld:0, uops:18'o111111, len:24'h222222, busy:0, e_take:4, e_bytes:8,
      e_val:4'hF, e_fus:0, e_icnt:8'h55, e_src:12'h688, e_uc:0, e_ucn:0, rq:2},
    // R5: pair at 1/2, five taken
    '{v:6'h3F, cmp:6'b000010, jcc:6'b000100, ld:0, uops:18'o111111, len:24'h654231, busy:0, e_take:5, e_bytes:15,
      e_val:4'hF, e_fus:4'b0010, e_icnt:8'h59, e_src:12'h8C8, e_uc:0, e_ucn:0, rq:5},
    // R5: second pair not fused
    '{v:6'h3F, cmp:6'b000101, jcc:6'b001010, ld:0, uops:18'o111111, len:24'h111111, busy:0, e_take:5, e_bytes:5,
      e_val:4'hF, e_fus:4'b0001, e_icnt:8'h56, e_src:12'h8D0, e_uc:0, e_ucn:0, rq:5},
    // R3 R4: 3-uop first then one simple
    '{v:6'h3F, cmp:0, jcc:0, ld:0, uops:18'o111113, len:24'h111117, busy:0, e_take:2, e_bytes:8,
      e_val:4'hF, e_fus:0, e_icnt:8'h55, e_src:12'h200, e_uc:0, e_ucn:0, rq:3},
    // R3: multi-uop in third place stops
    '{v:6'h3F, cmp:0, jcc:0, ld:0, uops:18'o111211, len:24'h333333, busy:0, e_take:2, e_bytes:6,
      e_val:4'h3, e_fus:0, e_icnt:8'h05, e_src:12'h008, e_uc:0, e_ucn:0, rq:3},
    // R6: load-op 3->2 and 2->1
    '{v:6'h3F, cmp:0, jcc:0, ld:6'b000011, uops:18'o111123, len:24'h111264, busy:0, e_take:3, e_bytes:12,
      e_val:4'hF, e_fus:4'b0101, e_icnt:8'h55, e_src:12'h440, e_uc:0, e_ucn:0, rq:6},
    // R7: long first goes to sequencer
    '{v:6'h3F, cmp:0, jcc:0, ld:0, uops:18'o111116, len:24'h111119, busy:0, e_take:1, e_bytes:9,
      e_val:0, e_fus:0, e_icnt:0, e_src:0, e_uc:1, e_ucn:6, rq:7},
    // R8: busy, also one-cycle pulse of R7
    '{v:6'h3F, cmp:0, jcc:0, ld:0, uops:18'o111116, len:24'h111119, busy:1, e_take:0, e_bytes:0,
      e_val:0, e_fus:0, e_icnt:0, e_src:0, e_uc:0, e_ucn:0, rq:8},
    // R7: long later stops
    '{v:6'h3F, cmp:0, jcc:0, ld:0, uops:18'o111511, len:24'h222222, busy:0, e_take:2, e_bytes:4,
      e_val:4'h3, e_fus:0, e_icnt:8'h05, e_src:12'h008, e_uc:0, e_ucn:0, rq:7},
    // R10: invalid entry 2 ends window, no pair
    '{v:6'b111011, cmp:6'b000010, jcc:6'b000100, ld:0, uops:18'o111111, len:24'h222222, busy:0, e_take:2, e_bytes:4,
      e_val:4'h3, e_fus:0, e_icnt:8'h05, e_src:12'h008, e_uc:0, e_ucn:0, rq:10},
    // R4: four-uop first fills bundle, R9 length 15
    '{v:6'h3F, cmp:0, jcc:0, ld:0, uops:18'o111114, len:24'h11111F, busy:0, e_take:1, e_bytes:15,
      e_val:4'hF, e_fus:0, e_icnt:8'h55, e_src:12'h000, e_uc:0, e_ucn:0, rq:4},
    // R10: empty window
    '{v:6'h00, cmp:0, jcc:0, ld:0, uops:18'o111111, len:24'h111111, busy:0, e_take:0, e_bytes:0,
      e_val:0, e_fus:0, e_icnt:0, e_src:0, e_uc:0, e_ucn:0, rq:10},
    // R5: pair in last decoder
    '{v:6'h3F, cmp:6'b001000, jcc:6'b010000, ld:0, uops:18'o111111, len:24'h111111, busy:0, e_take:5, e_bytes:5,
      e_val:4'hF, e_fus:4'b1000, e_icnt:8'h95, e_src:12'h688, e_uc:0, e_ucn:0, rq:5},
    // R6: load-op 5->4 stays in decoder 0
    '{v:6'h3F, cmp:0, jcc:0, ld:6'b000001, uops:18'o111115, len:24'h111113, busy:0, e_take:1, e_bytes:3,
      e_val:4'hF, e_fus:4'b0001, e_icnt:8'h55, e_src:12'h000, e_uc:0, e_ucn:0, rq:6}
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 32'(uop_valid), 0);
    chk("R1", "ucode_start in reset", 32'(ucode_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after release", 32'(uop_valid), 0);
    chk("R1", "ucode_uops after release", 32'(ucode_uops), 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d v%0d", VECS[i].rq, i);
      win_valid = VECS[i].v; win_cmp = VECS[i].cmp; win_jcc = VECS[i].jcc; win_ld = VECS[i].ld;
      win_uops = VECS[i].uops; win_len = VECS[i].len; ucode_busy = VECS[i].busy;
      #1;
      chk(rq, "in_ready", 32'(in_ready), 32'(!VECS[i].busy));
      chk(rq, "take_cnt", 32'(take_cnt), 32'(VECS[i].e_take));
      chk(rq, "take_bytes R9", 32'(take_bytes), 32'(VECS[i].e_bytes));
      @(negedge clk);
      chk(rq, "uop_valid", 32'(uop_valid), 32'(VECS[i].e_val));
      chk(rq, "uop_fused", 32'(uop_fused), 32'(VECS[i].e_fus));
      chk(rq, "uop_icnt", 32'(uop_icnt & {{2{uop_valid[3]}}, {2{uop_valid[2]}}, {2{uop_valid[1]}}, {2{uop_valid[0]}}}),
          32'(VECS[i].e_icnt));
      chk(rq, "uop_src", 32'(uop_src & {{3{VECS[i].e_val[3]}}, {3{VECS[i].e_val[2]}}, {3{VECS[i].e_val[1]}}, {3{VECS[i].e_val[0]}}}),
          32'(VECS[i].e_src));
      chk(rq, "ucode_start", 32'(ucode_start), 32'(VECS[i].e_uc));
      chk(rq, "ucode_uops", 32'(ucode_uops), 32'(VECS[i].e_ucn));
    end

    // R1: reset in mid-run clears a full bundle
    win_valid = 6'h3F; win_uops = 18'o111111; win_cmp = '0; win_jcc = '0; win_ld = '0; ucode_busy = 1'b0;
    @(negedge clk);
    chk("R1", "bundle full before reset", 32'(uop_valid), 32'hF);
    rst_n = 1'b0;
    #1;
    chk("R1", "bundle cleared by reset", 32'(uop_valid), 0);
    @(negedge clk);
    chk("R1", "bundle held clear", 32'(uop_valid), 0);
    rst_n = 1'b1;

    // R7: long entry via load-op (6 -> 5) still goes to the sequencer
    win_uops = 18'o111116; win_ld = 6'b000001;
    #1;
    chk("R7", "take_cnt load-op long", 32'(take_cnt), 1);
    @(negedge clk);
    chk("R7", "ucode_uops load-op long", 32'(ucode_uops), 5);
    win_valid = '0;
    @(negedge clk);
    chk("R7", "pulse ends", 32'(ucode_start), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule